// File: doc/BRIEF.md
# Dual-clock synchronous static memory with selectable output pipelining

This block is a synthesizable memory of 4096 words of 9 bits. It has two fully independent ports, A and B. Each port has its own clock and its own registered address, write data, select and direction inputs, so both ports can read or write at any time. A write lands in the array on the rising edge after the edge that registered it. A read returns the word at the registered address.

Port A always delivers read data through an output register, one edge after the address is registered. Port B follows a static mode input. When the mode input is high, port B behaves like port A. When it is low, port B shows the word combinationally in the cycle that follows the registering edge.

Each port also has three more controls:
- A hold input that freezes the whole port for an edge.
- An active-low select that deselects the port and quiets its output.
- An active-low output enable that gates the drive flag without waiting for a clock.

In place of a bidirectional pin, each port gives a data bus and an active-high drive flag. A collision flag reports when both ports are about to commit a write to the same word on the coming edge.

Top module: `dpr_sync_ram`

## Requirements
- R1: The array holds 2^AW words of DW bits (AW=12, DW=9 by default). A word written through either port reads back unchanged through either port, including addresses 0 and 4095.
- R2: A write is registered at a rising edge where select (`sel_n`) is 0, `wr_n` is 0 and hold is 0. It is committed to the array at the next rising edge where hold is 0. The drive flag stays low for a write.
- R3: On port A, a read is registered at edge k with `sel_n`=0 and `wr_n`=1. The drive flag is low after edge k. The flag and the data from the registered address are valid after edge k+1, provided `oe_n_a`=0.
- R4: Port B uses the port A timing when `pipe_b`=1. When `pipe_b`=0, the drive flag and the data are valid in the cycle right after edge k.
- R5: While `hold` is 1 at a rising edge, that port changes nothing on that edge: its address, data and control registers, its output register, its drive flag and its pending write all keep their values. A stalled write commits at the first edge after hold returns to 0.
- R6: Select high at an edge deselects the port. A flow-through port B drops its flag right after that edge. A pipelined port drops its flag after the following edge. After a deselect it drives again only after two edges taken with select low.
- R7: `oe_n` high forces that port's drive flag low at once, with no clock edge. Returning `oe_n` to 0 restores the flag at once.
- R8: A read on one port of a word written by the other port returns the new word when the read address is registered at or after the edge that commits the write. A flow-through reader shows the change right after the commit edge.
- R9: `clash` is 1 exactly while both ports hold a registered write to the same address and neither port's hold is 1. The stored word is then undefined.
- R10: With `rst_n` low at a rising edge, that port's pending read and write are cleared, no write commits on that edge, and the drive flags are low after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Synchronous active-low reset, sampled by each port clock |
| clk_a | input | 1 | Port A clock |
| hold_a | input | 1 | Port A stall, 1 freezes the port for the edge |
| sel_n_a | input | 1 | Port A select, active low |
| wr_n_a | input | 1 | Port A direction, 0 write, 1 read |
| addr_a | input | AW | Port A word address |
| din_a | input | DW | Port A write data |
| oe_n_a | input | 1 | Port A output enable, active low, asynchronous |
| q_a | output | DW | Port A read data |
| q_vld_a | output | 1 | Port A drive flag |
| clk_b | input | 1 | Port B clock |
| pipe_b | input | 1 | Port B mode, 1 pipelined, 0 flow-through |
| hold_b | input | 1 | Port B stall |
| sel_n_b | input | 1 | Port B select, active low |
| wr_n_b | input | 1 | Port B direction, 0 write, 1 read |
| addr_b | input | AW | Port B word address |
| din_b | input | DW | Port B write data |
| oe_n_b | input | 1 | Port B output enable, active low, asynchronous |
| q_b | output | DW | Port B read data |
| q_vld_b | output | 1 | Port B drive flag |
| clash | output | 1 | Both ports about to commit a write to one address |

## Verification
The assertions check several rules on every cycle:
- The read latency of the pipelined port and of flow-through port B.
- The quiet flag during writes and after a deselect, including the two-edge recovery.
- The instant effect of the output enable.
- The frozen output while port A is held.
- The reset state.

Only the bench scenarios can show the data-dependent behaviour, by comparing against a behavioural reference:
- Which word a read returns, including reads around a commit from the other port.
- That a stalled write lands once the hold is released.
- That the collision flag rises only for same-address writes.

// File: rtl/dpr_pkg.sv
// Package: shared defaults and the output-mode encoding for the dual-port memory.
// Assumes: consumers pick widths through parameters seeded from these defaults.
package dpr_pkg;
    localparam int unsigned ADDR_W_DEF = 12;
    localparam int unsigned DATA_W_DEF = 9;

    typedef enum logic {
        OUT_FLOW = 1'b0,
        OUT_PIPE = 1'b1
    } out_mode_e;
endpackage

// File: rtl/dpr_port_in.sv
// Module: input register stage of one port.
// Captures address, data and the decoded read/write request on each rising
// edge where hold is low. Assumes a synchronous active-low reset that clears
// only the request bits; address and data need no reset value.
module dpr_port_in #(
    parameter int unsigned AW = dpr_pkg::ADDR_W_DEF,
    parameter int unsigned DW = dpr_pkg::DATA_W_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic          sel_n,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [AW-1:0] a_q,
    output logic [DW-1:0] d_q,
    output logic          rd_q,
    output logic          wr_q
);
    // Request bits: decode select and direction, cleared by reset, frozen by hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= 1'b0;
            wr_q <= 1'b0;
        end else if (!hold) begin
            rd_q <= !sel_n && wr_n;
            wr_q <= !sel_n && !wr_n;
        end
    end

    // Address and data capture, frozen by hold.
    always_ff @(posedge clk) begin
        if (!hold) begin
            a_q <= addr;
            d_q <= din;
        end
    end
endmodule

// File: rtl/dpr_bank.sv
// Module: one storage bank, written from a single clock domain.
// Two combinational read taps serve both ports. Assumes the caller encodes
// write data so that the XOR of the two banks yields the stored word.
module dpr_bank #(
    parameter int unsigned AW = dpr_pkg::ADDR_W_DEF,
    parameter int unsigned DW = dpr_pkg::DATA_W_DEF
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_a,
    output logic [DW-1:0] rdata_b
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    // Single-writer array update.
    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata_a = cells[raddr_a];
    assign rdata_b = cells[raddr_b];
endmodule

// File: rtl/dpr_port_out.sv
// Module: output stage of one port.
// Holds the pipelined data register and its drive bit, then picks pipelined
// or flow-through delivery and gates the flag with the async output enable.
// Assumes mode is static during traffic and that a fixed-pipeline port ties
// mode to OUT_PIPE.
module dpr_port_out #(
    parameter int unsigned DW = dpr_pkg::DATA_W_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic          mode,
    input  logic          oe_n,
    input  logic          rd_q,
    input  logic [DW-1:0] word,
    output logic [DW-1:0] q,
    output logic          q_vld
);
    import dpr_pkg::*;

    logic [DW-1:0] pipe_d;
    logic          pipe_v;
    out_mode_e     sel_mode;

    assign sel_mode = out_mode_e'(mode);

    // Pipeline drive bit: follows the registered read one edge later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_v <= 1'b0;
        end else if (!hold) begin
            pipe_v <= rd_q;
        end
    end

    // Pipeline data register: samples the array word at the registered address.
    always_ff @(posedge clk) begin
        if (!hold) begin
            pipe_d <= word;
        end
    end

    // Delivery select and asynchronous output gating.
    always_comb begin
        if (sel_mode == OUT_PIPE) begin
            q     = pipe_d;
            q_vld = pipe_v && !oe_n;
        end else begin
            q     = word;
            q_vld = rd_q && !oe_n;
        end
    end
endmodule

// File: rtl/dpr_sync_ram.sv
// Module: dual-clock synchronous memory, port A fixed pipelined, port B selectable.
// Each port owns one bank; a word is the XOR of both banks at its address,
// so every bank has exactly one writing clock. Assumes simultaneous writes to
// one address from both ports leave that word undefined (flagged on clash).
module dpr_sync_ram #(
    parameter int unsigned AW = dpr_pkg::ADDR_W_DEF,
    parameter int unsigned DW = dpr_pkg::DATA_W_DEF
) (
    input  logic          rst_n,
    input  logic          clk_a,
    input  logic          hold_a,
    input  logic          sel_n_a,
    input  logic          wr_n_a,
    input  logic [AW-1:0] addr_a,
    input  logic [DW-1:0] din_a,
    input  logic          oe_n_a,
    output logic [DW-1:0] q_a,
    output logic          q_vld_a,
    input  logic          clk_b,
    input  logic          pipe_b,
    input  logic          hold_b,
    input  logic          sel_n_b,
    input  logic          wr_n_b,
    input  logic [AW-1:0] addr_b,
    input  logic [DW-1:0] din_b,
    input  logic          oe_n_b,
    output logic [DW-1:0] q_b,
    output logic          q_vld_b,
    output logic          clash
);
    logic [AW-1:0] aq_a, aq_b;
    logic [DW-1:0] dq_a, dq_b;
    logic          rd_a, rd_b, wr_a, wr_b;
    logic [DW-1:0] bka_at_a, bka_at_b, bkb_at_a, bkb_at_b;
    logic [DW-1:0] word_a, word_b;
    logic          we_a, we_b;

    dpr_port_in #(.AW(AW), .DW(DW)) u_in_a (
        .clk(clk_a), .rst_n(rst_n), .hold(hold_a), .sel_n(sel_n_a), .wr_n(wr_n_a),
        .addr(addr_a), .din(din_a), .a_q(aq_a), .d_q(dq_a), .rd_q(rd_a), .wr_q(wr_a)
    );

    dpr_port_in #(.AW(AW), .DW(DW)) u_in_b (
        .clk(clk_b), .rst_n(rst_n), .hold(hold_b), .sel_n(sel_n_b), .wr_n(wr_n_b),
        .addr(addr_b), .din(din_b), .a_q(aq_b), .d_q(dq_b), .rd_q(rd_b), .wr_q(wr_b)
    );

    // Commit enables: a registered write lands on the next unheld, non-reset edge.
    assign we_a = wr_a && !hold_a && rst_n;
    assign we_b = wr_b && !hold_b && rst_n;

    dpr_bank #(.AW(AW), .DW(DW)) u_bank_a (
        .clk(clk_a), .we(we_a), .waddr(aq_a), .wdata(dq_a ^ bkb_at_a),
        .raddr_a(aq_a), .raddr_b(aq_b), .rdata_a(bka_at_a), .rdata_b(bka_at_b)
    );

    dpr_bank #(.AW(AW), .DW(DW)) u_bank_b (
        .clk(clk_b), .we(we_b), .waddr(aq_b), .wdata(dq_b ^ bka_at_b),
        .raddr_a(aq_a), .raddr_b(aq_b), .rdata_a(bkb_at_a), .rdata_b(bkb_at_b)
    );

    // Stored word seen by each port: XOR of both banks.
    assign word_a = bka_at_a ^ bkb_at_a;
    assign word_b = bka_at_b ^ bkb_at_b;

    dpr_port_out #(.DW(DW)) u_out_a (
        .clk(clk_a), .rst_n(rst_n), .hold(hold_a), .mode(dpr_pkg::OUT_PIPE),
        .oe_n(oe_n_a), .rd_q(rd_a), .word(word_a), .q(q_a), .q_vld(q_vld_a)
    );

    dpr_port_out #(.DW(DW)) u_out_b (
        .clk(clk_b), .rst_n(rst_n), .hold(hold_b), .mode(pipe_b),
        .oe_n(oe_n_b), .rd_q(rd_b), .word(word_b), .q(q_b), .q_vld(q_vld_b)
    );

    // Same-address commit detection across ports.
    assign clash = we_a && we_b && (aq_a == aq_b);
endmodule

// File: rtl/dpr_chk.sv
// Module: temporal checks on the dual-port memory, attached with bind.
// Assumes both clocks are free-running; every property is gated by reset
// except the reset check itself.
module dpr_chk #(
    parameter int unsigned DW = dpr_pkg::DATA_W_DEF
) (
    input logic          rst_n,
    input logic          clk_a,
    input logic          hold_a,
    input logic          sel_n_a,
    input logic          wr_n_a,
    input logic          oe_n_a,
    input logic [DW-1:0] q_a,
    input logic          q_vld_a,
    input logic          clk_b,
    input logic          pipe_b,
    input logic          hold_b,
    input logic          sel_n_b,
    input logic          wr_n_b,
    input logic          oe_n_b,
    input logic          q_vld_b
);
    AST_A_READ_LATENCY: assert property (@(posedge clk_a) disable iff (!rst_n)
        (!hold_a && !sel_n_a && wr_n_a) ##1 !hold_a |=> (q_vld_a || oe_n_a)); // R3
    AST_A_WRITE_QUIET: assert property (@(posedge clk_a) disable iff (!rst_n)
        (!hold_a && !sel_n_a && !wr_n_a) ##1 !hold_a |=> !q_vld_a); // R2
    AST_A_DESEL_RECOVERY: assert property (@(posedge clk_a) disable iff (!rst_n)
        (!hold_a && sel_n_a) ##1 !hold_a |=> !q_vld_a); // R6
    AST_B_FLOW_DESEL: assert property (@(posedge clk_b) disable iff (!rst_n)
        (!hold_b && sel_n_b && !pipe_b) |=> (pipe_b || !q_vld_b)); // R6
    AST_B_FLOW_LATENCY: assert property (@(posedge clk_b) disable iff (!rst_n)
        (!hold_b && !sel_n_b && wr_n_b && !pipe_b) |=> (pipe_b || oe_n_b || q_vld_b)); // R4
    AST_A_HOLD_FROZEN: assert property (@(posedge clk_a) disable iff (!rst_n)
        hold_a |=> ($stable(q_a) && ($stable(q_vld_a) || !$stable(oe_n_a)))); // R5
    AST_A_OE_GATE: assert property (@(posedge clk_a) disable iff (!rst_n)
        oe_n_a |-> !q_vld_a); // R7
    AST_B_OE_GATE: assert property (@(posedge clk_b) disable iff (!rst_n)
        oe_n_b |-> !q_vld_b); // R7
    AST_RESET_QUIET: assert property (@(posedge clk_a)
        !rst_n |=> (!q_vld_a && !q_vld_b)); // R10
endmodule

bind dpr_sync_ram dpr_chk #(.DW(DW)) u_chk (
    .rst_n(rst_n), .clk_a(clk_a), .hold_a(hold_a), .sel_n_a(sel_n_a), .wr_n_a(wr_n_a),
    .oe_n_a(oe_n_a), .q_a(q_a), .q_vld_a(q_vld_a), .clk_b(clk_b), .pipe_b(pipe_b),
    .hold_b(hold_b), .sel_n_b(sel_n_b), .wr_n_b(wr_n_b), .oe_n_b(oe_n_b), .q_vld_b(q_vld_b)
);

// File: tb/dpr_sync_ram_test.sv
// Bench: behavioural reference model compared with the memory on every cycle,
// plus directed checks for latency, stall, deselect, enable and collision.
module dpr_sync_ram_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;
    localparam int DW = 9;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic          rst_n;
    logic          pipe_b;
    logic          hold  [2];
    logic          sel_n [2];
    logic          wr_n  [2];
    logic [AW-1:0] addr  [2];
    logic [DW-1:0] din   [2];
    logic          oe_n  [2];
    logic [DW-1:0] q     [2];
    logic          q_vld [2];
    logic          clash;

    dpr_sync_ram #(.AW(AW), .DW(DW)) uut (
        .rst_n(rst_n),
        .clk_a(clk), .hold_a(hold[0]), .sel_n_a(sel_n[0]), .wr_n_a(wr_n[0]),
        .addr_a(addr[0]), .din_a(din[0]), .oe_n_a(oe_n[0]), .q_a(q[0]), .q_vld_a(q_vld[0]),
        .clk_b(clk), .pipe_b(pipe_b), .hold_b(hold[1]), .sel_n_b(sel_n[1]), .wr_n_b(wr_n[1]),
        .addr_b(addr[1]), .din_b(din[1]), .oe_n_b(oe_n[1]), .q_b(q[1]), .q_vld_b(q_vld[1]),
        .clash(clash)
    );

    int    checks = 0;
    int    fails  = 0;
    string cur_req = "R10";
    bit    done = 1'b0;

    // Reference model state
    logic [DW-1:0] mdl_mem   [DEPTH];
    bit            mdl_known [DEPTH];
    logic [AW-1:0] m_aq [2];
    logic [DW-1:0] m_dq [2];
    logic [DW-1:0] m_pd [2];
    bit            m_pk [2];
    bit            m_rd [2];
    bit            m_wr [2];
    bit            m_pv [2];

    function automatic logic [DW-1:0] pat(input int a);
        return DW'((a * 37 + 5) & ((1 << DW) - 1));
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Model update on each rising edge
    always @(posedge clk) begin
        bit w0, w1;
        for (int p = 0; p < 2; p++) begin
            if (!hold[p]) begin
                m_pd[p] = mdl_mem[m_aq[p]];
                m_pk[p] = mdl_known[m_aq[p]];
            end
        end
        w0 = rst_n && m_wr[0] && !hold[0];
        w1 = rst_n && m_wr[1] && !hold[1];
        if (w0 && w1 && m_aq[0] == m_aq[1]) begin
            mdl_known[m_aq[0]] = 1'b0;
        end else begin
            if (w0) begin mdl_mem[m_aq[0]] = m_dq[0]; mdl_known[m_aq[0]] = 1'b1; end
            if (w1) begin mdl_mem[m_aq[1]] = m_dq[1]; mdl_known[m_aq[1]] = 1'b1; end
        end
        for (int p = 0; p < 2; p++) begin
            if (!rst_n) begin
                m_rd[p] = 1'b0; m_wr[p] = 1'b0; m_pv[p] = 1'b0;
            end else if (!hold[p]) begin
                m_pv[p] = m_rd[p];
                m_rd[p] = !sel_n[p] && wr_n[p];
                m_wr[p] = !sel_n[p] && !wr_n[p];
            end
            if (!hold[p]) begin
                m_aq[p] = addr[p];
                m_dq[p] = din[p];
            end
        end
    end

    task automatic compare_all();
        bit            ev, ek, pipe, ec;
        logic [DW-1:0] ed;
        for (int p = 0; p < 2; p++) begin
            pipe = (p == 0) || pipe_b;
            ev = !oe_n[p] && (pipe ? m_pv[p] : m_rd[p]);
            ed = pipe ? m_pd[p] : mdl_mem[m_aq[p]];
            ek = pipe ? m_pk[p] : mdl_known[m_aq[p]];
            chk(q_vld[p] == ev, cur_req, (p == 0) ? "flag A" : "flag B", int'(q_vld[p]), int'(ev));
            if (ev && ek) chk(q[p] == ed, cur_req, (p == 0) ? "data A" : "data B", int'(q[p]), int'(ed));
        end
        ec = m_wr[0] && m_wr[1] && !hold[0] && !hold[1] && (m_aq[0] == m_aq[1]);
        chk(clash == ec, cur_req, "clash", int'(clash), int'(ec));
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        #1;
        compare_all();
    endtask

    task automatic port_op(input int p, input bit s_n, input bit w_n, input int a, input int d);
        sel_n[p] = s_n; wr_n[p] = w_n; addr[p] = AW'(a); din[p] = DW'(d);
    endtask
    task automatic wr_op(input int p, input int a, input int d); port_op(p, 1'b0, 1'b0, a, d); endtask
    task automatic rd_op(input int p, input int a); port_op(p, 1'b0, 1'b1, a, 0); endtask
    task automatic nop(input int p); port_op(p, 1'b1, 1'b1, 0, 0); endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] held_q;
        rst_n = 1'b0; pipe_b = 1'b1;
        for (int p = 0; p < 2; p++) begin
            hold[p] = 1'b0; oe_n[p] = 1'b0; nop(p);
        end
        // R10: reset state
        cur_req = "R10";
        repeat (3) tick();
        chk(q_vld[0] == 1'b0, "R10", "reset flag A", int'(q_vld[0]), 0);
        chk(q_vld[1] == 1'b0, "R10", "reset flag B", int'(q_vld[1]), 0);
        chk(clash == 1'b0, "R10", "reset clash", int'(clash), 0);
        rst_n = 1'b1;
        tick();

        // R1/R2: fill through A, read back through both ports
        cur_req = "R1";
        wr_op(0, 0, pat(0));
        tick();
        chk(q_vld[0] == 1'b0, "R2", "write flag A", int'(q_vld[0]), 0);
        wr_op(0, 4095, pat(4095));
        tick();
        for (int i = 1; i <= 6; i++) begin wr_op(0, i, pat(i)); tick(); end
        nop(0); tick();
        for (int i = 0; i <= 6; i++) begin rd_op(0, i); rd_op(1, 6 - i); tick(); end
        nop(0); nop(1); tick(); tick();
        // R3: latency on port A at the top address
        cur_req = "R3";
        rd_op(0, 4095);
        tick();
        chk(q_vld[0] == 1'b0, "R3", "flag A after registering edge", int'(q_vld[0]), 0);
        nop(0);
        tick();
        chk(q_vld[0] == 1'b1, "R3", "flag A one edge later", int'(q_vld[0]), 1);
        chk(q[0] == pat(4095), "R3", "data A top address", int'(q[0]), int'(pat(4095)));
        tick();

        // R4: flow-through port B
        cur_req = "R4";
        pipe_b = 1'b0;
        tick();
        for (int i = 0; i < 4; i++) begin wr_op(1, 100 + i, pat(100 + i)); tick(); end
        nop(1);
        for (int i = 0; i < 4; i++) begin rd_op(0, 100 + i); tick(); end
        nop(0);
        rd_op(1, 102);
        tick();
        chk(q_vld[1] == 1'b1, "R4", "flow flag B same cycle", int'(q_vld[1]), 1);
        chk(q[1] == pat(102), "R4", "flow data B", int'(q[1]), int'(pat(102)));
        nop(1); tick(); tick();

        // R5: hold stalls a read and a write
        cur_req = "R5";
        rd_op(0, 1);
        tick();
        hold[0] = 1'b1; rd_op(0, 2);
        held_q = q[0];
        tick();
        chk(q_vld[0] == 1'b0, "R5", "stalled read flag A", int'(q_vld[0]), 0);
        chk(q[0] == held_q, "R5", "held data A", int'(q[0]), int'(held_q));
        tick();
        hold[0] = 1'b0;
        tick();
        chk(q[0] == pat(1), "R5", "first read after release", int'(q[0]), int'(pat(1)));
        nop(0);
        tick();
        chk(q[0] == pat(2), "R5", "second read after release", int'(q[0]), int'(pat(2)));
        wr_op(0, 10, 9'h0AA);
        tick();
        hold[0] = 1'b1; din[0] = 9'h155;
        tick(); tick();
        hold[0] = 1'b0; nop(0);
        tick();
        rd_op(1, 10);
        tick();
        chk(q[1] == 9'h0AA, "R5", "stalled write committed", int'(q[1]), 'h0AA);
        nop(1); tick();

        // R6: deselect recovery, pipelined then flow-through
        cur_req = "R6";
        pipe_b = 1'b1;
        tick();
        rd_op(0, 0); rd_op(1, 0);
        tick(); tick();
        nop(0); nop(1);
        tick();
        chk(q_vld[0] == 1'b1, "R6", "pipe flag A right after deselect", int'(q_vld[0]), 1);
        rd_op(0, 0); rd_op(1, 0);
        tick();
        chk(q_vld[0] == 1'b0, "R6", "pipe flag A one edge later", int'(q_vld[0]), 0);
        chk(q_vld[1] == 1'b0, "R6", "pipe flag B one edge later", int'(q_vld[1]), 0);
        tick();
        chk(q_vld[0] == 1'b1, "R6", "pipe flag A recovered", int'(q_vld[0]), 1);
        pipe_b = 1'b0;
        nop(1);
        tick();
        chk(q_vld[1] == 1'b0, "R6", "flow flag B off", int'(q_vld[1]), 0);
        rd_op(1, 0);
        tick();
        chk(q_vld[1] == 1'b1, "R6", "flow flag B back", int'(q_vld[1]), 1);

        // R7: asynchronous output enable
        cur_req = "R7";
        tick();
        oe_n[0] = 1'b1; oe_n[1] = 1'b1;
        #1;
        chk(q_vld[0] == 1'b0, "R7", "oe off A", int'(q_vld[0]), 0);
        chk(q_vld[1] == 1'b0, "R7", "oe off B", int'(q_vld[1]), 0);
        tick();
        oe_n[0] = 1'b0; oe_n[1] = 1'b0;
        #1;
        chk(q_vld[0] == 1'b1, "R7", "oe on A", int'(q_vld[0]), 1);
        chk(q_vld[1] == 1'b1, "R7", "oe on B", int'(q_vld[1]), 1);
        nop(0); nop(1); tick(); tick();

        // R8: cross-port commit seen by flow-through reader
        cur_req = "R8";
        wr_op(1, 200, 9'h033);
        tick();
        nop(1); tick();
        rd_op(1, 200); wr_op(0, 200, 9'h1C4);
        tick();
        chk(q[1] == 9'h033, "R8", "before commit", int'(q[1]), 'h033);
        nop(0);
        tick();
        chk(q[1] == 9'h1C4, "R8", "after commit", int'(q[1]), 'h1C4);
        nop(1);
        rd_op(0, 200); tick(); nop(0); tick(); tick();

        // R9: collision flag
        cur_req = "R9";
        wr_op(0, 301, 1); wr_op(1, 302, 2);
        tick();
        chk(clash == 1'b0, "R9", "different addresses", int'(clash), 0);
        wr_op(0, 300, 1); wr_op(1, 300, 2);
        tick();
        chk(clash == 1'b1, "R9", "same address", int'(clash), 1);
        nop(0); nop(1);
        tick();
        chk(clash == 1'b0, "R9", "after commit", int'(clash), 0);

        // R10: reset during traffic
        cur_req = "R10";
        rd_op(0, 4); rd_op(1, 5);
        tick(); tick();
        rst_n = 1'b0;
        tick();
        chk(q_vld[0] == 1'b0, "R10", "mid-run reset flag A", int'(q_vld[0]), 0);
        chk(q_vld[1] == 1'b0, "R10", "mid-run reset flag B", int'(q_vld[1]), 0);
        rst_n = 1'b1;
        nop(0); nop(1);
        tick();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule